// File: doc/BRIEF.md
# Cipher Round Sequencer

This block is the control unit for an iterative block-cipher datapath that applies one round per clock. It sits between a producer that writes plaintext or ciphertext blocks, a consumer that collects the results, a round-key memory filled in advance by a separate key expansion unit, and the round datapath itself. It only sequences: it tells the datapath when to capture a block and when to apply the initial step, each round and the final step. It also drives the round-key memory address. The arithmetic, the key expansion and the key storage live elsewhere.

After reset the sequencer refuses blocks until the key expansion unit reports a ready schedule, which it acknowledges. It then accepts one block per write strobe. It holds its busy flag until the consumer has taken the result, and it walks the round index up for encryption or down for decryption. The direction is latched at acceptance. The initial and final steps can each be removed by a parameter. With both present, a block takes ROUNDS+3 cycles from acceptance to result-valid.

Top module: `cipher_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset returns the unit to key-waiting with `round_idx`=0, `in_full`=0, `out_valid`=0 and all step outputs low.
- R2: While key-waiting, `wr_strobe` is ignored and `in_full` stays 0; `key_ack` is 1 in the cycle `key_valid` is seen while waiting, and 0 once the unit is ready.
- R3: A `wr_strobe` sampled while ready and idle is accepted: `step_load` is 1 and `in_full` is 1 in the cycle after the acceptance edge, and `in_full` stays 1 until the result is taken.
- R4: Encryption (`dir_sel`=0) presents index 0 with `step_init`, then indices 1 up to ROUNDS with `step_round` in consecutive cycles, then index ROUNDS with `step_final`.
- R5: Decryption (`dir_sel`=1) presents index ROUNDS with `step_init`, then indices ROUNDS down to 1 with `step_round`, then index 0 with `step_final`.
- R6: At most one step output is high in any cycle, and `out_valid` rises exactly ROUNDS+3 cycles after the acceptance edge.
- R7: `out_valid` stays 1 until `rd_ack` is sampled 1; on that edge both `out_valid` and `in_full` clear and the unit is ready for the next block.
- R8: A `wr_strobe` sampled while `in_full` is 1 is ignored, also when it falls in the same cycle as `rd_ack`; no later `step_load` results from it.
- R9: `dir_active` takes `dir_sel` at acceptance and holds it for the whole block; changing `dir_sel` mid-block has no effect on the index sequence.
- R10: With HAS_INIT=0 and HAS_FINAL=0 no initial or final step is issued; encryption rounds run 1 to ROUNDS directly after the load cycle and `out_valid` rises ROUNDS+1 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_sel | input | 1 | Direction for the next block: 0 encrypt, 1 decrypt |
| key_valid | input | 1 | Key schedule is complete in the round-key memory |
| key_ack | output | 1 | Acknowledge of the key schedule |
| wr_strobe | input | 1 | Producer offers a block |
| in_full | output | 1 | A block is held; further writes are ignored |
| out_valid | output | 1 | Result block is ready for the consumer |
| rd_ack | input | 1 | Consumer has taken the result |
| round_idx | output | IDX_W (4) | Round-key memory index |
| step_load | output | 1 | Datapath captures the input block |
| step_init | output | 1 | Datapath applies the initial step |
| step_round | output | 1 | Datapath applies one round |
| step_final | output | 1 | Datapath applies the final step |
| dir_active | output | 1 | Direction latched for the block in flight |

## Verification
Two events can share one cycle: the consumer's read acknowledge that releases the busy flag, and a producer write that would start the next block. Both are driven in the same cycle while a result is waiting. The run is judged at the ports: `out_valid` and `in_full` must both fall on that edge, and `step_load` must stay low afterwards, because the write was sampled while `in_full` was still high. Write strobes are also driven in mid-round and final-step cycles, and `dir_sel` is flipped during a block; the index sequence must stay unchanged in both cases.

// File: rtl/cipher_seq_pkg.sv
package cipher_seq_pkg;

   typedef enum logic [2:0] {
      ST_KEYWAIT = 3'd0,
      ST_IDLE    = 3'd1,
      ST_LOAD    = 3'd2,
      ST_INIT    = 3'd3,
      ST_ROUND   = 3'd4,
      ST_FINAL   = 3'd5,
      ST_HOLD    = 3'd6
   } seq_state_t;

endpackage

// File: rtl/cseq_fsm.sv
module cseq_fsm
   import cipher_seq_pkg::*;
#(
   parameter bit HAS_INIT  = 1'b1,
   parameter bit HAS_FINAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic key_valid,
   input  logic wr_strobe,
   input  logic last_round,
   input  logic rd_ack,
   output logic key_ack,
   output logic accept,
   output logic step_load,
   output logic step_init,
   output logic step_round,
   output logic step_final,
   output logic in_hold,
   output logic done
);

   seq_state_t st, nx, after_load, after_round;

   generate
      if (HAS_INIT) begin : g_init
         assign after_load = ST_INIT;
      end else begin : g_no_init
         assign after_load = ST_ROUND;
      end
      if (HAS_FINAL) begin : g_final
         assign after_round = ST_FINAL;
      end else begin : g_no_final
         assign after_round = ST_HOLD;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) st <= ST_KEYWAIT;
      else     st <= nx;
   end

   always_comb begin
      nx = st;
      unique case (st)
         ST_KEYWAIT: if (key_valid) nx = ST_IDLE;
         ST_IDLE:    if (wr_strobe) nx = ST_LOAD;
         ST_LOAD:    nx = after_load;
         ST_INIT:    nx = ST_ROUND;
         ST_ROUND:   if (last_round) nx = after_round;
         ST_FINAL:   nx = ST_HOLD;
         ST_HOLD:    if (rd_ack) nx = ST_IDLE;
         default:    nx = ST_KEYWAIT;
      endcase
   end

   assign key_ack    = (st == ST_KEYWAIT) && key_valid;
   assign accept     = (st == ST_IDLE) && wr_strobe;
   assign step_load  = (st == ST_LOAD);
   assign step_init  = (st == ST_INIT);
   assign step_round = (st == ST_ROUND);
   assign step_final = (st == ST_FINAL);
   assign in_hold    = (st == ST_HOLD);
   assign done       = (st != ST_HOLD) && (nx == ST_HOLD);

   assert_one_step_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot0({step_load, step_init, step_round, step_final}));

   assert_hold_waits_R7: assert property (@(posedge clk) disable iff (rst)
      (in_hold && !rd_ack) |=> in_hold);

endmodule

// File: rtl/cseq_round_ctr.sv
module cseq_round_ctr #(
   parameter int ROUNDS   = 12,
   parameter bit HAS_INIT = 1'b1,
   parameter int IDX_W    = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic             dir_sel,
   input  logic             dir_active,
   input  logic             step_init,
   input  logic             step_round,
   output logic [IDX_W-1:0] round_idx,
   output logic             last_round
);

   localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(ROUNDS);
   localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);
   localparam logic [IDX_W-1:0] ENC_START = HAS_INIT ? '0 : IDX_ONE;

   logic [IDX_W-1:0] idx_q;

   assign last_round = dir_active ? (idx_q == IDX_ONE) : (idx_q == IDX_TOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
      end else if (accept) begin
         idx_q <= dir_sel ? IDX_TOP : ENC_START;
      end else if (step_round) begin
         if (dir_active)       idx_q <= idx_q - IDX_ONE;
         else if (!last_round) idx_q <= idx_q + IDX_ONE;
      end else if (step_init && !dir_active) begin
         idx_q <= idx_q + IDX_ONE;
      end
   end

   assign round_idx = idx_q;

   assert_idx_bound_R4: assert property (@(posedge clk) disable iff (rst)
      idx_q <= IDX_TOP);

   assert_idx_moves_R5: assert property (@(posedge clk) disable iff (rst)
      (step_round && !last_round) |=> (idx_q != $past(idx_q)));

endmodule

// File: rtl/cseq_flags.sv
module cseq_flags (
   input  logic clk,
   input  logic rst,
   input  logic accept,
   input  logic done,
   input  logic release_blk,
   input  logic dir_sel,
   output logic in_full,
   output logic out_valid,
   output logic dir_active
);

   always_ff @(posedge clk) begin
      if (rst) begin
         in_full    <= 1'b0;
         out_valid  <= 1'b0;
         dir_active <= 1'b0;
      end else begin
         if (accept)           in_full <= 1'b1;
         else if (release_blk) in_full <= 1'b0;
         if (done)             out_valid <= 1'b1;
         else if (release_blk) out_valid <= 1'b0;
         if (accept)           dir_active <= dir_sel;
      end
   end

   assert_valid_within_full_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> in_full);

   assert_dir_stable_R9: assert property (@(posedge clk) disable iff (rst)
      (in_full && !release_blk) |=> $stable(dir_active));

endmodule

// File: rtl/cipher_seq_ctrl.sv
module cipher_seq_ctrl #(
   parameter int ROUNDS    = 12,
   parameter bit HAS_INIT  = 1'b1,
   parameter bit HAS_FINAL = 1'b1,
   parameter int IDX_W     = $clog2(ROUNDS + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dir_sel,
   input  logic             key_valid,
   output logic             key_ack,
   input  logic             wr_strobe,
   output logic             in_full,
   output logic             out_valid,
   input  logic             rd_ack,
   output logic [IDX_W-1:0] round_idx,
   output logic             step_load,
   output logic             step_init,
   output logic             step_round,
   output logic             step_final,
   output logic             dir_active
);

   localparam int IDX_NEED = $clog2(ROUNDS + 1);

   generate
      if (ROUNDS < 2) begin : g_bad_rounds
         $error("cipher_seq_ctrl: ROUNDS must be at least 2");
      end
      if (IDX_W < IDX_NEED) begin : g_bad_width
         $error("cipher_seq_ctrl: IDX_W too narrow for ROUNDS");
      end
   endgenerate

   logic accept, done, in_hold, last_round, release_blk;

   cseq_fsm #(
      .HAS_INIT  (HAS_INIT),
      .HAS_FINAL (HAS_FINAL)
   ) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .key_valid  (key_valid),
      .wr_strobe  (wr_strobe),
      .last_round (last_round),
      .rd_ack     (rd_ack),
      .key_ack    (key_ack),
      .accept     (accept),
      .step_load  (step_load),
      .step_init  (step_init),
      .step_round (step_round),
      .step_final (step_final),
      .in_hold    (in_hold),
      .done       (done)
   );

   cseq_round_ctr #(
      .ROUNDS   (ROUNDS),
      .HAS_INIT (HAS_INIT),
      .IDX_W    (IDX_W)
   ) u_ctr (
      .clk        (clk),
      .rst        (rst),
      .accept     (accept),
      .dir_sel    (dir_sel),
      .dir_active (dir_active),
      .step_init  (step_init),
      .step_round (step_round),
      .round_idx  (round_idx),
      .last_round (last_round)
   );

   assign release_blk = in_hold && rd_ack;

   cseq_flags u_flags (
      .clk         (clk),
      .rst         (rst),
      .accept      (accept),
      .done        (done),
      .release_blk (release_blk),
      .dir_sel     (dir_sel),
      .in_full     (in_full),
      .out_valid   (out_valid),
      .dir_active  (dir_active)
   );

   logic rst_seen;
   always_ff @(posedge clk) rst_seen <= rst;

   always_ff @(posedge clk) begin
      if (rst_seen) begin
         assert_reset_state_R1: assert (round_idx == '0 && !in_full && !out_valid
                                        && !step_load && !step_round);
      end
   end

   assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
      (in_full && wr_strobe) |=> !step_load);

   assert_key_gate_R2: assert property (@(posedge clk) disable iff (rst)
      key_ack |-> !in_full);

endmodule

// File: tb/cipher_seq_ctrl_bench.sv
module cipher_seq_ctrl_bench;

   localparam int CLK_PER = 10;
   localparam int NR      = 12;
   localparam int NR_LITE = 4;

   // vector fields: [10] wr with ack, [9] dir, [8] flip dir, [7:4] hold, [3:0] busy-write cycle
   localparam logic [10:0] VEC [4] = '{
      {1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
      {1'b0, 1'b1, 1'b1, 4'd3, 4'd5},
      {1'b0, 1'b0, 1'b1, 4'd1, 4'd14},
      {1'b1, 1'b1, 1'b0, 4'd0, 4'd1}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic dir_sel = 1'b0, key_valid = 1'b0, wr_strobe = 1'b0, rd_ack = 1'b0;
   logic wr2 = 1'b0, rd2 = 1'b0;
   logic key_ack, in_full, out_valid, step_load, step_init, step_round, step_final, dir_active;
   logic [3:0] round_idx;
   logic key_ack2, full2, valid2, load2, init2, round2, final2, dir2;
   logic [2:0] idx2;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PER/2) clk = ~clk;

   cipher_seq_ctrl u_cipher_seq_ctrl (
      .clk(clk), .rst(rst), .dir_sel(dir_sel), .key_valid(key_valid), .key_ack(key_ack),
      .wr_strobe(wr_strobe), .in_full(in_full), .out_valid(out_valid), .rd_ack(rd_ack),
      .round_idx(round_idx), .step_load(step_load), .step_init(step_init),
      .step_round(step_round), .step_final(step_final), .dir_active(dir_active)
   );

   cipher_seq_ctrl #(.ROUNDS(NR_LITE), .HAS_INIT(1'b0), .HAS_FINAL(1'b0)) u_cipher_seq_ctrl_lite (
      .clk(clk), .rst(rst), .dir_sel(dir_sel), .key_valid(key_valid), .key_ack(key_ack2),
      .wr_strobe(wr2), .in_full(full2), .out_valid(valid2), .rd_ack(rd2),
      .round_idx(idx2), .step_load(load2), .step_init(init2),
      .step_round(round2), .step_final(final2), .dir_active(dir2)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_block(input logic [10:0] v);
      logic d;
      d = v[9];
      @(negedge clk); wr_strobe = 1'b1; dir_sel = d;
      @(negedge clk); wr_strobe = 1'b0;
      chk("R3 load after accept", step_load, 1);
      chk("R3 full after accept", in_full, 1);
      chk("R9 dir latched", dir_active, d);
      if (v[8]) dir_sel = ~d;
      for (int c = 1; c <= NR + 3; c++) begin
         if (v[3:0] == c) wr_strobe = 1'b1;
         @(negedge clk); wr_strobe = 1'b0;
         if (c == 1) begin
            chk("R4/R5 init step", step_init, 1);
            chk("R4/R5 init index", round_idx, d ? NR : 0);
         end else if (c <= NR + 1) begin
            chk("R4/R5 round step", step_round, 1);
            chk("R4/R5 round index", round_idx, d ? NR + 2 - c : c - 1);
         end else if (c == NR + 2) begin
            chk("R4/R5 final step", step_final, 1);
            chk("R4/R5 final index", round_idx, d ? 0 : NR);
         end
         if (c < NR + 3) chk("R6 valid not early", out_valid, 0);
         else begin
            chk("R6 valid at latency", out_valid, 1);
            chk("R3 full while valid", in_full, 1);
         end
      end
      for (int h = 0; h < int'(v[7:4]); h++) begin
         @(negedge clk);
         chk("R7 valid held", out_valid, 1);
         chk("R7 full held", in_full, 1);
      end
      chk("R9 dir held", dir_active, d);
      rd_ack = 1'b1; wr_strobe = v[10];
      @(negedge clk); rd_ack = 1'b0; wr_strobe = 1'b0;
      chk("R7 valid cleared", out_valid, 0);
      chk("R7 full cleared", in_full, 0);
      @(negedge clk);
      chk("R8 no stray load", step_load, 0);
      chk("R8 still empty", in_full, 0);
   endtask

   initial begin
      #(CLK_PER * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      chk("R1 reset index", round_idx, 0);
      chk("R1 reset full", in_full, 0);
      chk("R1 reset valid", out_valid, 0);
      rst = 1'b0;
      // R2: writes before key ready are ignored
      wr_strobe = 1'b1;
      @(negedge clk); wr_strobe = 1'b0;
      chk("R2 no ack without key", key_ack, 0);
      @(negedge clk);
      chk("R2 write ignored full", in_full, 0);
      chk("R2 write ignored load", step_load, 0);
      key_valid = 1'b1; #1;
      chk("R2 key ack", key_ack, 1);
      @(negedge clk);
      chk("R2 ack drops when ready", key_ack, 0);

      foreach (VEC[i]) run_block(VEC[i]);

      // R10: variant without initial and final steps
      @(negedge clk); wr2 = 1'b1; dir_sel = 1'b0;
      @(negedge clk); wr2 = 1'b0;
      chk("R10 lite load", load2, 1);
      for (int c = 1; c <= NR_LITE + 1; c++) begin
         @(negedge clk);
         chk("R10 lite no init", init2, 0);
         chk("R10 lite no final", final2, 0);
         if (c <= NR_LITE) begin
            chk("R10 lite round", round2, 1);
            chk("R10 lite index", idx2, c);
            chk("R10 lite not valid", valid2, 0);
         end else chk("R10 lite valid", valid2, 1);
      end
      rd2 = 1'b1;
      @(negedge clk); rd2 = 1'b0;
      chk("R10 lite release", full2, 0);

      // R1: reset in the middle of a block
      @(negedge clk); wr_strobe = 1'b1; dir_sel = 1'b1;
      @(negedge clk); wr_strobe = 1'b0;
      repeat (5) @(negedge clk);
      key_valid = 1'b0; rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R1 mid reset index", round_idx, 0);
      chk("R1 mid reset full", in_full, 0);
      chk("R1 mid reset round step", step_round, 0);
      wr_strobe = 1'b1;
      @(negedge clk); wr_strobe = 1'b0;
      @(negedge clk);
      chk("R2 write ignored after reset", in_full, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule